// File: doc/BRIEF.md
# Dual-Lane 16-bit Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing execution unit. Each operation arrives as two packed 32-bit operand words, X and Y. Each word carries two signed 16-bit halves. Two independent lanes each multiply one pair of halves. Lane 0 takes the low halves and lane 1 takes the high halves. Each lane then folds its 32-bit product into a private 40-bit accumulator. The eight guard bits above the product width let long sums run without overflow.

The datapath has two register stages. The first stage captures the products and the per-lane opcode. The second stage updates the accumulators. A new operation can therefore be issued on every clock. Each lane has its own opcode bits. One bit selects subtract instead of add. A second bit makes the lane start from zero, so the signed product (or its negation) is loaded. A single enable makes the sum clamp at the 40-bit signed limits instead of wrapping. The accumulators drive the outputs directly.

Top module: `dmac_dual16`

## Requirements
- R1: While `rst_n` is low, both accumulators are forced to 0 and any operation in flight is discarded.
- R2: Lane 0 multiplies bits [15:0] of `x_word` and `y_word`, and lane 1 multiplies bits [31:16]. Both products are signed two's-complement. Lane 0's accumulator is `acc_out[39:0]` and lane 1's is `acc_out[79:40]`.
- R3: With `lane_sub[i]`=0 and `lane_clr[i]`=0, an issued operation sets accumulator i to its old value plus the product.
- R4: With `lane_sub[i]`=1 and `lane_clr[i]`=0, an issued operation sets accumulator i to its old value minus the product.
- R5: With `lane_clr[i]`=1, an issued operation loads accumulator i with the product, or with the negated product when `lane_sub[i]`=1. The old value is discarded.
- R6: An operation sampled at rising edge k is visible on `acc_out` after rising edge k+1. Operations issued on consecutive cycles into the same accumulator each see the result of the one before.
- R7: A cycle with `op_valid` low changes no accumulator, whatever the operand, opcode and saturation inputs are.
- R8: With `sat_en`=1 when the operation is issued, a result above 2^39-1 becomes 2^39-1 and a result below -2^39 becomes -2^39.
- R9: With `sat_en`=0, the result wraps modulo 2^40.
- R10: The opcode bits of one lane have no effect on the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Issue strobe for one dual operation |
| x_word | input | 32 | Packed X operands, lane 0 in the low half |
| y_word | input | 32 | Packed Y operands, lane 0 in the low half |
| lane_sub | input | 2 | Per-lane subtract select |
| lane_clr | input | 2 | Per-lane load (start from zero) select |
| sat_en | input | 1 | Clamp instead of wrap for this operation |
| acc_out | output | 80 | Both accumulators, lane 0 in bits [39:0] |

## Verification
The bound checker tests a set of rules on every cycle:
- reset zeroes the accumulators;
- an issue always fills the product stage one edge later;
- an empty product stage leaves the accumulators unchanged;
- a load without subtract puts the exact sign-extended product into the accumulator;
- a saturating add of two non-negative values never turns negative.

Other behaviour needs the bench's scenarios with a reference model. This covers the exact arithmetic of accumulate and subtract over corner operands. It also covers independent opcodes in the two lanes and chains of back-to-back operations. Two long runs drive an accumulator to its clamp points and then past the wrap point.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   // Decoded per-lane accumulator action
   typedef enum logic [1:0] {
      ACT_ADD  = 2'b00,
      ACT_SUB  = 2'b01,
      ACT_LOAD = 2'b10,
      ACT_NLOAD = 2'b11
   } dmac_act_e;

   function automatic dmac_act_e decode_act(input logic clr, input logic sub);
      dmac_act_e a;
      case ({clr, sub})
         2'b00:   a = ACT_ADD;
         2'b01:   a = ACT_SUB;
         2'b10:   a = ACT_LOAD;
         default: a = ACT_NLOAD;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/dmac_mul_lane.sv
module dmac_mul_lane #(
   parameter int OP_W = 16,
   localparam int PW = 2 * OP_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic [OP_W-1:0] x_in,
   input  logic [OP_W-1:0] y_in,
   input  logic            sub_in,
   input  logic            clr_in,
   output logic [PW-1:0]   prod_q,
   output logic            sub_q,
   output logic            clr_q
);

   logic signed [PW-1:0] prod_d;

   always_comb begin
      prod_d = $signed(x_in) * $signed(y_in);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q <= '0;
         sub_q  <= 1'b0;
         clr_q  <= 1'b0;
      end else if (issue) begin
         prod_q <= prod_d;
         sub_q  <= sub_in;
         clr_q  <= clr_in;
      end
   end

endmodule

// File: rtl/dmac_acc_lane.sv
module dmac_acc_lane
   import dmac_pkg::*;
#(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter bit SAT_OPT = 1'b1,
   localparam int PW = 2 * OP_W,
   localparam int SW = ACC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             sat,
   input  logic             sub,
   input  logic             clr,
   input  logic [PW-1:0]    prod,
   output logic [ACC_W-1:0] acc_q
);

   localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

   dmac_act_e          act;
   logic [SW-1:0]      base_x;
   logic [SW-1:0]      prod_x;
   logic [SW-1:0]      sum_x;
   logic               ovf;
   logic [ACC_W-1:0]   acc_d;

   always_comb begin
      act    = decode_act(clr, sub);
      prod_x = {{(SW-PW){prod[PW-1]}}, prod};
      base_x = (act == ACT_LOAD || act == ACT_NLOAD) ? '0 : {acc_q[ACC_W-1], acc_q};
      if (act == ACT_SUB || act == ACT_NLOAD) sum_x = base_x - prod_x;
      else                                    sum_x = base_x + prod_x;
      ovf = sum_x[SW-1] ^ sum_x[SW-2];
   end

   generate
      if (SAT_OPT) begin : g_sat
         always_comb begin
            if (sat && ovf) acc_d = sum_x[SW-1] ? NEG_LIM : POS_LIM;
            else            acc_d = sum_x[ACC_W-1:0];
         end
      end else begin : g_wrap
         logic unused_sat;
         always_comb begin
            unused_sat = sat ^ ovf;
            acc_d      = sum_x[ACC_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   acc_q <= '0;
      else if (upd) acc_q <= acc_d;
   end

endmodule

// File: rtl/dmac_dual16.sv
module dmac_dual16 #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int LANES   = 2,
   parameter bit SAT_OPT = 1'b1,
   localparam int PW    = 2 * OP_W,
   localparam int WORD_W = LANES * OP_W,
   localparam int OUT_W  = LANES * ACC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [WORD_W-1:0] x_word,
   input  logic [WORD_W-1:0] y_word,
   input  logic [LANES-1:0]  lane_sub,
   input  logic [LANES-1:0]  lane_clr,
   input  logic              sat_en,
   output logic [OUT_W-1:0]  acc_out
);

   generate
      if (ACC_W < PW + 1) begin : g_bad_acc
         $error("dmac_dual16: ACC_W must exceed the product width");
      end
      if (OP_W < 2) begin : g_bad_op
         $error("dmac_dual16: OP_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("dmac_dual16: LANES must be at least 1");
      end
   endgenerate

   // Stage 1 shared control
   logic s1_valid;
   logic s1_sat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sat   <= 1'b0;
      end else begin
         s1_valid <= op_valid;
         if (op_valid) s1_sat <= sat_en;
      end
   end

   logic [LANES*PW-1:0] s1_prod_flat;
   logic [LANES-1:0]    s1_sub;
   logic [LANES-1:0]    s1_clr;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         dmac_mul_lane #(.OP_W(OP_W)) i_mul (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (op_valid),
            .x_in   (x_word[l*OP_W +: OP_W]),
            .y_in   (y_word[l*OP_W +: OP_W]),
            .sub_in (lane_sub[l]),
            .clr_in (lane_clr[l]),
            .prod_q (s1_prod_flat[l*PW +: PW]),
            .sub_q  (s1_sub[l]),
            .clr_q  (s1_clr[l])
         );

         dmac_acc_lane #(.OP_W(OP_W), .ACC_W(ACC_W), .SAT_OPT(SAT_OPT)) i_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (s1_valid),
            .sat   (s1_sat),
            .sub   (s1_sub[l]),
            .clr   (s1_clr[l]),
            .prod  (s1_prod_flat[l*PW +: PW]),
            .acc_q (acc_out[l*ACC_W +: ACC_W])
         );
      end
   endgenerate

endmodule

// File: rtl/dmac_dual16_chk.sv
module dmac_dual16_chk #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int LANES   = 2,
   parameter bit SAT_OPT = 1'b1,
   localparam int PW = 2 * OP_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   op_valid,
   input logic                   s1_valid,
   input logic                   s1_sat,
   input logic [LANES-1:0]       s1_sub,
   input logic [LANES-1:0]       s1_clr,
   input logic [LANES*PW-1:0]    s1_prod_flat,
   input logic [LANES*ACC_W-1:0] acc_out
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> acc_out == '0);

   // R6
   issue_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> s1_valid);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(acc_out));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lchk
         // R5
         load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && s1_clr[l] && !s1_sub[l]) |=>
            acc_out[l*ACC_W +: ACC_W] ==
               {{(ACC_W-PW){$past(s1_prod_flat[l*PW+PW-1])}}, $past(s1_prod_flat[l*PW +: PW])});

         if (SAT_OPT) begin : g_satchk
            // R8
            no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (s1_valid && s1_sat && !s1_clr[l] && !s1_sub[l] &&
                !s1_prod_flat[l*PW+PW-1] && !acc_out[l*ACC_W+ACC_W-1]) |=>
               !acc_out[l*ACC_W+ACC_W-1]);
         end
      end
   endgenerate

endmodule

bind dmac_dual16 dmac_dual16_chk #(
   .OP_W(OP_W), .ACC_W(ACC_W), .LANES(LANES), .SAT_OPT(SAT_OPT)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .s1_valid     (s1_valid),
   .s1_sat       (s1_sat),
   .s1_sub       (s1_sub),
   .s1_clr       (s1_clr),
   .s1_prod_flat (s1_prod_flat),
   .acc_out      (acc_out)
);

// File: tb/test_dmac_dual16.sv
`timescale 1ns/1ps
module test_dmac_dual16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [31:0] x_word = '0;
   logic [31:0] y_word = '0;
   logic [1:0]  lane_sub = '0;
   logic [1:0]  lane_clr = '0;
   logic        sat_en = 1'b0;
   logic [79:0] acc_out;

   int checks = 0;
   int fails  = 0;

   localparam longint POS_L = 64'sd549755813887;
   localparam longint NEG_L = -64'sd549755813888;

   always #2.5 clk = ~clk;

   dmac_dual16 i_dmac_dual16 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
      .x_word(x_word), .y_word(y_word),
      .lane_sub(lane_sub), .lane_clr(lane_clr),
      .sat_en(sat_en), .acc_out(acc_out)
   );

   // reference state: model, one and two ops back
   longint mdl [2];
   longint e0 [2];
   longint e1 [2];
   string  tag0 = "R1";
   string  tag1 = "R1";

   function automatic longint mstep(longint a, longint p, bit sub, bit clr, bit sat);
      longint t;
      t = clr ? 64'sd0 : a;
      t = sub ? t - p : t + p;
      if (sat) begin
         if (t > POS_L) t = POS_L;
         if (t < NEG_L) t = NEG_L;
      end else begin
         t = {{24{t[39]}}, t[39:0]};
      end
      return t;
   endfunction

   task automatic check_lanes(string tag);
      for (int l = 0; l < 2; l++) begin
         logic [39:0] got, exp;
         got = acc_out[l*40 +: 40];
         exp = e1[l][39:0];
         checks++;
         if (got !== exp) begin
            fails++;
            $display("FAIL %s lane%0d: got %h expected %h", tag, l, got, exp);
         end
      end
   endtask

   task automatic step(bit v, logic [15:0] x0, logic [15:0] y0, logic [15:0] x1,
                       logic [15:0] y1, logic [1:0] sb, logic [1:0] cl, bit st,
                       string tag);
      longint p0, p1;
      @(negedge clk);
      check_lanes(tag1);
      e1   = e0;
      tag1 = tag0;
      op_valid = v;
      x_word   = {x1, x0};
      y_word   = {y1, y0};
      lane_sub = sb;
      lane_clr = cl;
      sat_en   = st;
      // R2: lane 0 low halves, lane 1 high halves, signed
      p0 = longint'($signed(x0)) * longint'($signed(y0));
      p1 = longint'($signed(x1)) * longint'($signed(y1));
      if (v) begin
         mdl[0] = mstep(mdl[0], p0, sb[0], cl[0], st);
         mdl[1] = mstep(mdl[1], p1, sb[1], cl[1], st);
      end
      e0   = mdl;
      tag0 = tag;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      op_valid = 1'b0;
      repeat (2) @(negedge clk);
      for (int l = 0; l < 2; l++) begin
         checks++;
         if (acc_out[l*40 +: 40] !== 40'd0) begin
            fails++;
            $display("FAIL R1 reset lane%0d: got %h expected 0", l, acc_out[l*40 +: 40]);
         end
      end
      mdl = '{0, 0};
      e0  = '{0, 0};
      e1  = '{0, 0};
      tag0 = "R1";
      tag1 = "R1";
      rst_n = 1'b1;
   endtask

   function automatic string op_tag(logic [1:0] k);
      if (k[1])      return "R5 load";
      else if (k[0]) return "R4 subtract";
      else           return "R3 accumulate";
   endfunction

   logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                             16'h8000, 16'h8001, 16'h0002, 16'h1234};

   initial begin
      mdl = '{0, 0};
      e0  = '{0, 0};
      e1  = '{0, 0};
      do_reset();

      // R3 R4 R5 R6 R10: back-to-back sweep with different opcodes per lane
      for (int ps = 0; ps < 2; ps++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               logic [1:0] k0, k1;
               k0 = 2'((i * 8 + j + ps) % 4);
               k1 = 2'((i * 8 + j + ps + 1) % 4);
               step(1'b1, vals[i], vals[j], vals[7-j], vals[(i+3)%8],
                    {k1[0], k0[0]}, {k1[1], k0[1]}, ps[0], op_tag(k0));
            end
         end
      end

      // R7: idle cycles with busy inputs leave state alone
      for (int n = 0; n < 8; n++)
         step(1'b0, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, 2'(n), 2'(n >> 2), 1'b1,
              "R7 idle");

      // R8: drive lane 0 to positive clamp, lane 1 to negative clamp
      step(1'b1, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b11, 1'b1, "R5 load zero");
      for (int n = 0; n < 600; n++)
         step(1'b1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 2'b10, 2'b00, 1'b1,
              "R8 clamp");

      // R9: without clamp the same run wraps around
      for (int n = 0; n < 600; n++)
         step(1'b1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 2'b10, 2'b00, 1'b0,
              "R9 wrap");

      // flush the pipeline
      step(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b00, 1'b0, "R7 idle");
      step(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b00, 1'b0, "R7 idle");
      step(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b00, 1'b0, "R7 idle");

      // R1: reset in the middle of a run clears state
      step(1'b1, 16'h1234, 16'h0100, 16'h8000, 16'h7FFF, 2'b00, 2'b00, 1'b0, "R3 accumulate");
      do_reset();
      step(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b00, 1'b0, "R1 after reset");
      step(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 2'b00, 2'b00, 1'b0, "R1 after reset");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule